// File: doc/BRIEF.md
# Serial NAND Feature Register File

This block is the feature and status register set on the device side of a serial NAND flash. It sits between the command decoder and the operation engine. The decoder sends single-cycle strobes for write-enable, write-disable, set-feature, get-feature and the reset command, along with an 8-bit feature address and a data byte. The engine sends start requests and a completion pulse that carries a fail flag and a 2-bit ECC result. In return the block supplies the byte read back for a get-feature, and qualified go signals for read, program and erase.

The block also holds the settings that the engine and the I/O logic need: the write-enable latch, the quad enable, the ECC enable, the OTP controls, the block-protect fields and the output drive strength. Protection writes are gated by the register-write-disable bit together with the write-protect pin. The status bits follow their own rules, set and cleared as operations start and finish. A reset command returns the status bits to their idle values and leaves every configuration setting untouched.

Top module: `sflash_feature_file`

## Requirements
- R1: `cmd_wren` sets the write-enable latch (status bit 1, port `wel`) and `cmd_wrdis` clears it. It is 0 after power-up.
- R2: `read_go` equals `read_req` while not busy. `prog_go` and `erase_go` equal their requests only while `wel`=1 and not busy. A request that is not granted changes no state.
- R3: Protection register at address A0h: bit 7 is write-disable (`lock_brwd`), bits 5:3 are protect bits (`lock_bp`), bit 2 is `lock_inv`, bit 1 is `lock_cmp`. Bits 6 and 0 read 0.
- R4: A set-feature to A0h leaves bits 7 and 5:1 unchanged when bit 7 is 1 and `wp_n` is 0. Otherwise it writes them.
- R5: Config register at B0h: bit 7 `otp_prt`, bit 6 `otp_en`, bit 4 `ecc_en`, bit 0 `quad_en`. Drive register at D0h holds `drive_str` in bits 6:5. All other bits of both registers read 0.
- R6: Status at C0h reads {2'b00, ecc[1:0], program-fail, erase-fail, wel, busy}. A set-feature to C0h has no effect.
- R7: After power-up, A0h=3Eh, B0h=10h, C0h=00h and D0h=00h.
- R8: A granted read clears the ECC field to 00. The `op_done` that ends the read loads `ecc_code` into it (00 clean, 01 corrected, 10 uncorrectable).
- R9: A granted program clears program-fail, and its `op_done` loads `op_fail` into it. Erase-fail behaves the same way for erase.
- R10: `busy` becomes 1 the cycle after a granted read, program or erase, or after `cmd_reset`. It returns to 0 the cycle after `op_done`.
- R11: `cmd_reset` clears the ECC field and both fail bits, and leaves A0h, B0h, D0h and `wel` unchanged.
- R12: `wel` is cleared when a program or erase completes, whether it passes or fails.
- R13: `cmd_getf` captures the addressed register into `rd_data`, which is valid on the next cycle and held until the next get-feature. Unmapped addresses read 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| cmd_wren | input | 1 | Write-enable command strobe |
| cmd_wrdis | input | 1 | Write-disable command strobe |
| cmd_setf | input | 1 | Set-feature strobe |
| cmd_getf | input | 1 | Get-feature strobe |
| cmd_reset | input | 1 | Device reset command strobe |
| feat_addr | input | 8 | Feature address |
| feat_wdata | input | 8 | Set-feature data |
| wp_n | input | 1 | Write-protect pin, active low |
| read_req | input | 1 | Array read request |
| prog_req | input | 1 | Program execute request |
| erase_req | input | 1 | Block erase request |
| op_done | input | 1 | Operation completion pulse |
| op_fail | input | 1 | Fail flag, valid with op_done |
| ecc_code | input | 2 | ECC result, valid with op_done of a read |
| rd_data | output | 8 | Get-feature read-back byte |
| read_go | output | 1 | Read granted |
| prog_go | output | 1 | Program granted |
| erase_go | output | 1 | Erase granted |
| busy | output | 1 | Operation in progress |
| wel | output | 1 | Write-enable latch |
| quad_en | output | 1 | Quad transfers enabled |
| ecc_en | output | 1 | Internal ECC enabled |
| otp_en | output | 1 | OTP area selected |
| otp_prt | output | 1 | OTP protect |
| lock_brwd | output | 1 | Protect-register write disable |
| lock_bp | output | 3 | Block protect bits |
| lock_inv | output | 1 | Protect range invert |
| lock_cmp | output | 1 | Protect range complement |
| drive_str | output | 2 | Output drive strength |

## Verification
Most internal faults reach the ports directly. A latch, protection field or configuration bit in the wrong state shows on its dedicated output on the next cycle. A wrong write-enable or busy bit also appears at once as a wrong grant on the very next request.

Faults in the status bits, such as ECC and fail bits loaded from the wrong operation or not cleared at a start or reset, stay hidden until a get-feature of C0h. They then appear one cycle after that strobe. The bench therefore reads status during operations, after each kind of completion, and after the reset command. A reference model then compares every register after each cycle of a long random command mix.

// File: rtl/sflash_feature_pkg.sv
package sflash_feature_pkg;
  localparam int FW   = 8;
  localparam int ECCW = 2;
  localparam int BPW  = 3;
  localparam int DSW  = 2;
  localparam int NREG = 3;

  // Index order of the writable feature registers
  localparam int IDX_LOCK = 0;
  localparam int IDX_CFG  = 1;
  localparam int IDX_DRV  = 2;

  localparam logic [FW-1:0] ADDR_STAT = 8'hC0;
  localparam logic [FW-1:0] REG_ADDR  [NREG] = '{8'hA0, 8'hB0, 8'hD0};
  localparam logic [FW-1:0] REG_WMASK [NREG] = '{8'hBE, 8'hD1, 8'h60};
  localparam logic [FW-1:0] REG_RSTV  [NREG] = '{8'h3E, 8'h10, 8'h00};

  // Bit positions decoded by neighbouring logic
  localparam int LK_BRWD = 7;
  localparam int LK_BP_LO = 3;
  localparam int LK_INV  = 2;
  localparam int LK_CMP  = 1;
  localparam int CF_OPRT = 7;
  localparam int CF_OEN  = 6;
  localparam int CF_ECC  = 4;
  localparam int CF_QE   = 0;
  localparam int DR_LO   = 5;

  typedef enum logic [2:0] {
    OPK_NONE, OPK_READ, OPK_PROG, OPK_ERASE, OPK_RESET
  } opk_t;

  typedef struct packed {
    logic [ECCW-1:0] ecc;
    logic            pfail;
    logic            efail;
    logic            wel;
    logic            oip;
  } stat_t;
endpackage

// File: rtl/sflash_feat_reg.sv
module sflash_feat_reg
  import sflash_feature_pkg::*;
#(
  parameter logic [FW-1:0] WMASK = 8'hFF,
  parameter logic [FW-1:0] RSTV  = 8'h00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [FW-1:0] wdata,
  output logic [FW-1:0] q
);
  logic [FW-1:0] q_d;

  always_comb begin
    q_d = q;
    if (wr_en) q_d = wdata & WMASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RSTV;
    else        q <= q_d;
  end
endmodule

// File: rtl/sflash_status.sv
module sflash_status
  import sflash_feature_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wren,
  input  logic            wrdis,
  input  logic            rst_cmd,
  input  logic            rd_go,
  input  logic            pg_go,
  input  logic            er_go,
  input  logic            op_done,
  input  logic            op_fail,
  input  logic [ECCW-1:0] ecc_in,
  output stat_t           stat
);
  stat_t stat_d;
  opk_t  kind_q, kind_d;

  always_comb begin
    stat_d = stat;
    kind_d = kind_q;
    if (op_done && stat.oip) begin
      case (kind_q)
        OPK_READ:  stat_d.ecc = ecc_in;
        OPK_PROG:  begin stat_d.pfail = op_fail; stat_d.wel = 1'b0; end
        OPK_ERASE: begin stat_d.efail = op_fail; stat_d.wel = 1'b0; end
        default:   ;
      endcase
      stat_d.oip = 1'b0;
      kind_d     = OPK_NONE;
    end
    if (rd_go) begin
      stat_d.ecc = '0;
      stat_d.oip = 1'b1;
      kind_d     = OPK_READ;
    end
    if (pg_go) begin
      stat_d.pfail = 1'b0;
      stat_d.oip   = 1'b1;
      kind_d       = OPK_PROG;
    end
    if (er_go) begin
      stat_d.efail = 1'b0;
      stat_d.oip   = 1'b1;
      kind_d       = OPK_ERASE;
    end
    if (rst_cmd) begin
      stat_d.ecc   = '0;
      stat_d.pfail = 1'b0;
      stat_d.efail = 1'b0;
      stat_d.oip   = 1'b1;
      kind_d       = OPK_RESET;
    end
    if (wren)       stat_d.wel = 1'b1;
    else if (wrdis) stat_d.wel = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat   <= '0;
      kind_q <= OPK_NONE;
    end else begin
      stat   <= stat_d;
      kind_q <= kind_d;
    end
  end
endmodule

// File: rtl/sflash_readback.sv
module sflash_readback
  import sflash_feature_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          getf,
  input  logic [FW-1:0] addr,
  input  logic [FW-1:0] regs [NREG],
  input  logic [FW-1:0] stat_byte,
  output logic [FW-1:0] rd_data
);
  logic [FW-1:0] sel, rd_d;

  always_comb begin
    sel = '0;
    if (addr == ADDR_STAT) sel = stat_byte;
    for (int i = 0; i < NREG; i++)
      if (addr == REG_ADDR[i]) sel = regs[i];
    rd_d = getf ? sel : rd_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= rd_d;
  end
endmodule

// File: rtl/sflash_feature_file.sv
module sflash_feature_file
  import sflash_feature_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_wren,
  input  logic            cmd_wrdis,
  input  logic            cmd_setf,
  input  logic            cmd_getf,
  input  logic            cmd_reset,
  input  logic [7:0]      feat_addr,
  input  logic [7:0]      feat_wdata,
  input  logic            wp_n,
  input  logic            read_req,
  input  logic            prog_req,
  input  logic            erase_req,
  input  logic            op_done,
  input  logic            op_fail,
  input  logic [1:0]      ecc_code,
  output logic [7:0]      rd_data,
  output logic            read_go,
  output logic            prog_go,
  output logic            erase_go,
  output logic            busy,
  output logic            wel,
  output logic            quad_en,
  output logic            ecc_en,
  output logic            otp_en,
  output logic            otp_prt,
  output logic            lock_brwd,
  output logic [2:0]      lock_bp,
  output logic            lock_inv,
  output logic            lock_cmp,
  output logic [1:0]      drive_str
);
  // Reset: asserted asynchronously, released on the clock
  logic rst_meta_n, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  logic [FW-1:0] feat_q [NREG];
  logic [NREG-1:0] wr_sel;
  logic lock_guard;
  stat_t stat;
  logic [1:0] stat_ecc;

  assign lock_guard = feat_q[IDX_LOCK][LK_BRWD] & ~wp_n;

  always_comb begin
    for (int i = 0; i < NREG; i++)
      wr_sel[i] = cmd_setf && (feat_addr == REG_ADDR[i]) &&
                  !((i == IDX_LOCK) && lock_guard);
  end

  for (genvar g = 0; g < NREG; g++) begin : g_feat
    sflash_feat_reg #(.WMASK(REG_WMASK[g]), .RSTV(REG_RSTV[g])) u_reg (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .wr_en (wr_sel[g]),
      .wdata (feat_wdata),
      .q     (feat_q[g])
    );
  end

  assign read_go  = read_req & ~stat.oip;
  assign prog_go  = prog_req & stat.wel & ~stat.oip;
  assign erase_go = erase_req & stat.wel & ~stat.oip;

  sflash_status u_status (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wren    (cmd_wren),
    .wrdis   (cmd_wrdis),
    .rst_cmd (cmd_reset),
    .rd_go   (read_go),
    .pg_go   (prog_go),
    .er_go   (erase_go),
    .op_done (op_done),
    .op_fail (op_fail),
    .ecc_in  (ecc_code),
    .stat    (stat)
  );

  assign stat_ecc = stat.ecc;

  sflash_readback u_rb (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .getf      (cmd_getf),
    .addr      (feat_addr),
    .regs      (feat_q),
    .stat_byte ({2'b00, stat.ecc, stat.pfail, stat.efail, stat.wel, stat.oip}),
    .rd_data   (rd_data)
  );

  assign busy      = stat.oip;
  assign wel       = stat.wel;
  assign lock_brwd = feat_q[IDX_LOCK][LK_BRWD];
  assign lock_bp   = feat_q[IDX_LOCK][LK_BP_LO +: BPW];
  assign lock_inv  = feat_q[IDX_LOCK][LK_INV];
  assign lock_cmp  = feat_q[IDX_LOCK][LK_CMP];
  assign otp_prt   = feat_q[IDX_CFG][CF_OPRT];
  assign otp_en    = feat_q[IDX_CFG][CF_OEN];
  assign ecc_en    = feat_q[IDX_CFG][CF_ECC];
  assign quad_en   = feat_q[IDX_CFG][CF_QE];
  assign drive_str = feat_q[IDX_DRV][DR_LO +: DSW];
endmodule

// File: rtl/sflash_feature_file_chk.sv
module sflash_feature_file_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_wren,
  input logic       cmd_wrdis,
  input logic       cmd_setf,
  input logic       cmd_reset,
  input logic [7:0] feat_addr,
  input logic       wp_n,
  input logic       prog_req,
  input logic       erase_req,
  input logic       read_go,
  input logic       prog_go,
  input logic       erase_go,
  input logic       busy,
  input logic       wel,
  input logic       quad_en,
  input logic       ecc_en,
  input logic       lock_brwd,
  input logic [2:0] lock_bp,
  input logic       lock_inv,
  input logic       lock_cmp,
  input logic [1:0] drive_str,
  input logic [1:0] stat_ecc
);
  assert_wel_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wren |=> wel);

  assert_wel_clr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wrdis && !cmd_wren) |=> !wel);

  assert_no_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((prog_req || erase_req) && !wel) |-> (!prog_go && !erase_go));

  assert_lock_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_setf && feat_addr == 8'hA0 && lock_brwd && !wp_n)
      |=> $stable({lock_brwd, lock_bp, lock_inv, lock_cmp}));

  assert_ecc_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    read_go |=> (stat_ecc == 2'b00));

  assert_busy_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (read_go || prog_go || erase_go || cmd_reset) |=> busy);

  assert_reset_keeps_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_reset && !cmd_setf)
      |=> $stable({quad_en, ecc_en, lock_brwd, lock_bp, lock_inv, lock_cmp, drive_str}));
endmodule

bind sflash_feature_file sflash_feature_file_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .cmd_wren  (cmd_wren),
  .cmd_wrdis (cmd_wrdis),
  .cmd_setf  (cmd_setf),
  .cmd_reset (cmd_reset),
  .feat_addr (feat_addr),
  .wp_n      (wp_n),
  .prog_req  (prog_req),
  .erase_req (erase_req),
  .read_go   (read_go),
  .prog_go   (prog_go),
  .erase_go  (erase_go),
  .busy      (busy),
  .wel       (wel),
  .quad_en   (quad_en),
  .ecc_en    (ecc_en),
  .lock_brwd (lock_brwd),
  .lock_bp   (lock_bp),
  .lock_inv  (lock_inv),
  .lock_cmp  (lock_cmp),
  .drive_str (drive_str),
  .stat_ecc  (stat_ecc)
);

// File: tb/sflash_feature_file_bench.sv
module sflash_feature_file_bench;
  localparam int A_IDLE = 0, A_WREN = 1, A_WRDIS = 2, A_SETF = 3, A_GETF = 4,
                 A_READ = 5, A_PROG = 6, A_ERASE = 7, A_DONE = 8, A_RST = 9;
  localparam int K_NONE = 0, K_READ = 1, K_PROG = 2, K_ERASE = 3, K_RST = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_wren, cmd_wrdis, cmd_setf, cmd_getf, cmd_reset;
  logic [7:0] feat_addr, feat_wdata;
  logic wp_n, read_req, prog_req, erase_req, op_done, op_fail;
  logic [1:0] ecc_code;
  logic [7:0] rd_data;
  logic read_go, prog_go, erase_go, busy, wel, quad_en, ecc_en, otp_en, otp_prt;
  logic lock_brwd, lock_inv, lock_cmp;
  logic [2:0] lock_bp;
  logic [1:0] drive_str;

  always #4 clk = ~clk;

  sflash_feature_file u_sflash_feature_file (.*);

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  // Reference model state
  logic [7:0] m_lock, m_cfg, m_drv, m_rd;
  logic m_wel, m_oip, m_pf, m_ef;
  logic [1:0] m_ecc;
  int m_kind;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model_read(input logic [7:0] a);
    case (a)
      8'hA0:   return m_lock;
      8'hB0:   return m_cfg;
      8'hC0:   return {2'b00, m_ecc, m_pf, m_ef, m_wel, m_oip};
      8'hD0:   return m_drv;
      default: return 8'h00;
    endcase
  endfunction

  task automatic clear_in();
    cmd_wren = 0; cmd_wrdis = 0; cmd_setf = 0; cmd_getf = 0; cmd_reset = 0;
    read_req = 0; prog_req = 0; erase_req = 0; op_done = 0; op_fail = 0;
    ecc_code = 0; feat_addr = 0; feat_wdata = 0;
  endtask

  task automatic check_state();
    chk("R1 wel", wel, m_wel);
    chk("R10 busy", busy, m_oip);
    chk("R3 lock", {lock_brwd, lock_bp, lock_inv, lock_cmp},
        {m_lock[7], m_lock[5:3], m_lock[2], m_lock[1]});
    chk("R5 cfg", {otp_prt, otp_en, ecc_en, quad_en},
        {m_cfg[7], m_cfg[6], m_cfg[4], m_cfg[0]});
    chk("R5 drive", drive_str, m_drv[6:5]);
    chk("R13 rd_data", rd_data, m_rd);
  endtask

  task automatic act(input int a, input logic [7:0] ad, input logic [7:0] d,
                     input logic f, input logic [1:0] e, input logic wp);
    logic erg, epg, eer;
    @(negedge clk);
    check_state();
    clear_in();
    wp_n = wp;
    feat_addr = ad; feat_wdata = d; op_fail = f; ecc_code = e;
    case (a)
      A_WREN:  cmd_wren = 1;
      A_WRDIS: cmd_wrdis = 1;
      A_SETF:  cmd_setf = 1;
      A_GETF:  cmd_getf = 1;
      A_READ:  read_req = 1;
      A_PROG:  prog_req = 1;
      A_ERASE: erase_req = 1;
      A_DONE:  op_done = 1;
      A_RST:   cmd_reset = 1;
      default: ;
    endcase
    #1;
    erg = read_req & !m_oip;
    epg = prog_req & m_wel & !m_oip;
    eer = erase_req & m_wel & !m_oip;
    chk("R2 read_go", read_go, erg);
    chk("R2 prog_go", prog_go, epg);
    chk("R2 erase_go", erase_go, eer);
    @(posedge clk);
    if (cmd_getf) m_rd = model_read(ad);
    if (cmd_setf) begin
      if (ad == 8'hA0 && !(m_lock[7] && !wp)) m_lock = d & 8'hBE;
      if (ad == 8'hB0) m_cfg = d & 8'hD1;
      if (ad == 8'hD0) m_drv = d & 8'h60;
    end
    if (op_done && m_oip) begin
      if (m_kind == K_READ) m_ecc = e;
      if (m_kind == K_PROG) begin m_pf = f; m_wel = 0; end
      if (m_kind == K_ERASE) begin m_ef = f; m_wel = 0; end
      m_oip = 0; m_kind = K_NONE;
    end
    if (erg) begin m_ecc = 0; m_oip = 1; m_kind = K_READ; end
    if (epg) begin m_pf = 0; m_oip = 1; m_kind = K_PROG; end
    if (eer) begin m_ef = 0; m_oip = 1; m_kind = K_ERASE; end
    if (cmd_reset) begin m_ecc = 0; m_pf = 0; m_ef = 0; m_oip = 1; m_kind = K_RST; end
    if (cmd_wren) m_wel = 1;
    else if (cmd_wrdis) m_wel = 0;
    #1 clear_in();
  endtask

  task automatic rd_feat(input logic [7:0] a, output logic [7:0] v);
    act(A_GETF, a, 8'h00, 0, 2'b00, wp_n);
    @(negedge clk);
    v = rd_data;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd2024));
    clear_in();
    wp_n = 1;
    rst_n = 0;
    m_lock = 8'h3E; m_cfg = 8'h10; m_drv = 8'h00; m_rd = 8'h00;
    m_wel = 0; m_oip = 0; m_pf = 0; m_ef = 0; m_ecc = 0; m_kind = K_NONE;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);

    // Power-up values
    rd_feat(8'hA0, v); chk("R7 A0", v, 8'h3E);
    rd_feat(8'hB0, v); chk("R7 B0", v, 8'h10);
    rd_feat(8'hC0, v); chk("R7 C0", v, 8'h00);
    rd_feat(8'hD0, v); chk("R7 D0", v, 8'h00);

    // Program without write enable is ignored
    act(A_PROG, 0, 0, 0, 0, 1);
    @(negedge clk); chk("R2 ignored prog busy", busy, 1'b0);

    // Failing program
    act(A_WREN, 0, 0, 0, 0, 1);
    @(negedge clk); chk("R1 wel set", wel, 1'b1);
    act(A_PROG, 0, 0, 0, 0, 1);
    @(negedge clk); chk("R10 busy after prog", busy, 1'b1);
    act(A_READ, 0, 0, 0, 0, 1);
    act(A_DONE, 0, 0, 1, 0, 1);
    @(negedge clk); chk("R12 wel cleared", wel, 1'b0);
    rd_feat(8'hC0, v); chk("R9 pfail set", v, 8'h08);
    act(A_WREN, 0, 0, 0, 0, 1);
    act(A_PROG, 0, 0, 0, 0, 1);
    rd_feat(8'hC0, v); chk("R9 pfail cleared at start", v, 8'h03);
    act(A_DONE, 0, 0, 0, 0, 1);

    // Failing erase
    act(A_WREN, 0, 0, 0, 0, 1);
    act(A_ERASE, 0, 0, 0, 0, 1);
    act(A_DONE, 0, 0, 1, 0, 1);
    rd_feat(8'hC0, v); chk("R9 efail set", v, 8'h04);

    // ECC status
    act(A_READ, 0, 0, 0, 0, 1);
    act(A_DONE, 0, 0, 0, 2'b10, 1);
    rd_feat(8'hC0, v); chk("R8 ecc uncorrectable", v, 8'h24);
    act(A_READ, 0, 0, 0, 0, 1);
    rd_feat(8'hC0, v); chk("R8 ecc cleared at start", v, 8'h05);
    act(A_DONE, 0, 0, 0, 2'b01, 1);
    rd_feat(8'hC0, v); chk("R8 ecc corrected", v, 8'h14);

    // Status is read-only
    act(A_SETF, 8'hC0, 8'hFF, 0, 0, 1);
    rd_feat(8'hC0, v); chk("R6 status write ignored", v, 8'h14);

    // Masks
    act(A_SETF, 8'hB0, 8'hFF, 0, 0, 1);
    rd_feat(8'hB0, v); chk("R5 B0 mask", v, 8'hD1);
    act(A_SETF, 8'hD0, 8'hFF, 0, 0, 1);
    rd_feat(8'hD0, v); chk("R5 D0 mask", v, 8'h60);
    act(A_SETF, 8'hA0, 8'hFF, 0, 0, 1);
    rd_feat(8'hA0, v); chk("R3 A0 mask", v, 8'hBE);

    // Write protection of the lock register
    act(A_SETF, 8'hA0, 8'h00, 0, 0, 0);
    rd_feat(8'hA0, v); chk("R4 locked write blocked", v, 8'hBE);
    act(A_SETF, 8'hA0, 8'h00, 0, 0, 1);
    rd_feat(8'hA0, v); chk("R4 write with wp high", v, 8'h00);
    act(A_SETF, 8'hA0, 8'h3E, 0, 0, 0);
    rd_feat(8'hA0, v); chk("R4 write with brwd clear", v, 8'h3E);

    // Reset command
    act(A_RST, 0, 0, 0, 0, 1);
    @(negedge clk); chk("R10 busy after reset", busy, 1'b1);
    rd_feat(8'hC0, v); chk("R11 status cleared", v, 8'h01);
    act(A_DONE, 0, 0, 0, 0, 1);
    rd_feat(8'hB0, v); chk("R11 B0 kept", v, 8'hD1);
    rd_feat(8'hD0, v); chk("R11 D0 kept", v, 8'h60);
    rd_feat(8'hA0, v); chk("R11 A0 kept", v, 8'h3E);
    rd_feat(8'h55, v); chk("R13 unmapped", v, 8'h00);

    // Random mix against the model
    for (int i = 0; i < 4000; i++) begin
      int a;
      logic [7:0] ad;
      int sel;
      a = $urandom_range(9, 0);
      if (m_oip && ($urandom_range(3, 0) == 0)) a = A_DONE;
      sel = $urandom_range(4, 0);
      case (sel)
        0: ad = 8'hA0;
        1: ad = 8'hB0;
        2: ad = 8'hC0;
        3: ad = 8'hD0;
        default: ad = 8'($urandom);
      endcase
      act(a, ad, 8'($urandom), 1'($urandom), 2'($urandom_range(2, 0)),
          1'($urandom_range(3, 0) != 0));
    end
    @(negedge clk);
    check_state();

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule